// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a parameterized set of interrupt inputs (twenty by default) and drives a single request line to one processor. Each input has its own configuration word. The word holds a mask, a read-only activity flag, a polarity, a level/edge selector, a 4-bit priority and an 8-bit vector. Inputs pass through one register stage. Level-sensed inputs are pending for as long as the input matches the chosen polarity. Edge-sensed inputs latch a pending flag on the chosen transition.

The processor claims an interrupt by reading the acknowledge location. That read returns the vector of the winning source and places the source in service on a nesting stack. The processor retires the most recent claim by writing zero to the end-of-interrupt location. A source wins only when its priority is strictly above two values: the current task priority, and the priority of the source on top of the service stack. Among equal priorities the lowest source index wins. A global control word starts a timed soft reset and holds a mode bit that reads back as written.

All accesses use a simple word-addressed register bus. Read data is combinational from the address. Side effects such as claiming take place on the clock edge that ends a read or write strobe.

Top module: `irqc_top`

## Requirements
- R1: After reset the global word reads 0, the task priority reads 15, and every source word reads 0x8000_0000. `irq_out` is low and an acknowledge read returns 0xFF.
- R2: The word addresses are: global word 0x00, task priority 0x01, acknowledge 0x02, end-of-interrupt 0x03, and source i at 0x20+i. A source word has mask in bit 31, activity in bit 30 (read-only), polarity in bit 23 (1 = high/rising), sense in bit 22 (1 = level, 0 = edge), priority in bits 19:16 and vector in bits 7:0. All other bits read 0, and written fields read back.
- R3: A source whose mask bit is 1 is never delivered: `irq_out` stays low for it and acknowledge returns 0xFF. Writing the mask bit to 0 makes the source eligible.
- R4: A level source is pending, and its activity bit reads 1, while its input equals its polarity bit.
- R5: An unmasked edge source latches pending on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The latch holds after the input returns to its idle level, and an acknowledge of that source clears it.
- R6: The delivered source has the highest priority among unmasked pending sources that are not in service, with ties going to the lowest index. It must also have a priority strictly greater than both the task priority and the priority of the top in-service entry.
- R7: An acknowledge read returns the winner's vector in bits 7:0, or 0xFF when nothing qualifies. A successful read puts the source in service, and its activity bit then reads 1.
- R8: Writing 0 to the end-of-interrupt location retires the most recently acknowledged source that is still in service. A nonzero write there has no effect.
- R9: While a source's activity bit is 1, writes to it leave polarity, sense, priority and vector unchanged, but the mask bit is still written.
- R10: The task priority holds 0..15, taken from bits 3:0 of a write. At value 15 every source is blocked.
- R11: Writing 1 to global bit 31 starts a soft reset. For RST_CYC cycles bit 31 reads 1, `irq_out` is low and bus writes are ignored. The bit then clears itself, and every source word and the task priority are back at their reset values.
- R12: Global bit 29 holds the mode selection (1 mixed, 0 pass-through) and reads back as written. A soft reset does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for acknowledge side effect) |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_in | input | NSRC | Raw interrupt inputs |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A table drives pairs of level sources with different priorities, equal priorities and various task-priority values. This separates the highest-priority choice, the lowest-index tie-break, and the strict-greater threshold (an equal task priority must block). Directed sequences nest three claims with interleaved retirements. They show that end-of-interrupt pops the most recent entry rather than the oldest, and that a nonzero write does nothing. Rising and falling pulses on an edge source show that the pending latch outlives the input and is cleared by the claim. Writes to an active, masked source show that its configuration is frozen while the mask stays writable. A soft reset issued while a request is pending shows the busy window, the forced-low output, and the return to defaults with the mode bit kept.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;
  localparam logic [VEC_W-1:0] SPURIOUS_VEC = 8'hFF;

  typedef struct packed {
    logic              pol;    // 1: active high / rising
    logic              level;  // 1: level sensed, 0: edge sensed
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;

  localparam src_cfg_t CFG_RESET = '{pol: 1'b0, level: 1'b0, prio: '0, vec: '0};

  function automatic logic [31:0] pack_src(logic mask, logic act, src_cfg_t c);
    return {mask, act, 6'b0, c.pol, c.level, 2'b0, c.prio, 8'b0, c.vec};
  endfunction

  function automatic src_cfg_t unpack_cfg(logic [31:0] w);
    src_cfg_t c;
    c.pol   = w[23];
    c.level = w[22];
    c.prio  = w[19:16];
    c.vec   = w[7:0];
    return c;
  endfunction

  function automatic logic edge_hit(logic pol, logic now, logic prev);
    return pol ? (now & ~prev) : (~now & prev);
  endfunction

  function automatic logic level_hit(logic pol, logic now);
    return now == pol;
  endfunction

  function automatic logic [PRIO_W-1:0] prio_max(logic [PRIO_W-1:0] a, logic [PRIO_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/irqc_source.sv
module irqc_source
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        in_now,
  input  logic        in_prev,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        ack_take,
  input  logic        retire,
  output src_cfg_t    cfg,
  output logic        mask,
  output logic        active,
  output logic        in_svc,
  output logic        cand
);
  logic edge_pend;
  logic edge_now;
  logic level_now;
  logic pend;

  assign edge_now  = !cfg.level && !mask && edge_hit(cfg.pol, in_now, in_prev);
  assign level_now = cfg.level && level_hit(cfg.pol, in_now);
  assign pend      = cfg.level ? level_now : edge_pend;
  assign active    = pend | in_svc;
  assign cand      = pend & ~mask & ~in_svc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= 1'b1;
      cfg       <= CFG_RESET;
      edge_pend <= 1'b0;
      in_svc    <= 1'b0;
    end else if (clr) begin
      mask      <= 1'b1;
      cfg       <= CFG_RESET;
      edge_pend <= 1'b0;
      in_svc    <= 1'b0;
    end else begin
      if (wr_en) begin
        mask <= wdata[31];
        if (!active) cfg <= unpack_cfg(wdata);
      end
      if (edge_now)      edge_pend <= 1'b1;
      else if (ack_take) edge_pend <= 1'b0;
      if (ack_take)      in_svc <= 1'b1;
      else if (retire)   in_svc <= 1'b0;
    end
  end

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && active && !clr) |=> (cfg == $past(cfg)));

  assert_edge_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !cfg.level && !edge_now && !clr) |=> !edge_pend);

  assert_ack_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !clr) |=> in_svc);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NSRC = 20,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]             cand,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]           thresh,
  output logic                        win_valid,
  output logic [IW-1:0]               win_idx
);
  logic [PRIO_W-1:0] best;

  // Strict compare keeps the earliest index on ties and enforces prio > thresh.
  always_comb begin
    best      = thresh;
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (prio[i] > best)) begin
        best      = prio[i];
        win_valid = 1'b1;
        win_idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_nest_stack.sv
module irqc_nest_stack #(
  parameter int DEPTH = 16,
  parameter int IW    = 5,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [IW-1:0] top_idx,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [IW-1:0] mem [DEPTH];
  logic          full;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign top_idx = empty ? '0 : mem[AW'(count - CW'(1))];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (push && !full) begin
      mem[AW'(count)] <= push_idx;
      count           <= count + CW'(1);
    end else if (pop && !empty) begin
      count <= count - CW'(1);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC    = 20,
  parameter int NEST    = 16,
  parameter int RST_CYC = 4,
  localparam int IW     = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int RCW    = $clog2(RST_CYC + 1),
  localparam int CW     = $clog2(NEST + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] irq_in,
  output logic            irq_out
);
  localparam logic [7:0] A_GLOBAL = 8'h00;
  localparam logic [7:0] A_TASK   = 8'h01;
  localparam logic [7:0] A_ACK    = 8'h02;
  localparam logic [7:0] A_EOI    = 8'h03;
  localparam logic [7:0] A_SRC    = 8'h20;

  logic [NSRC-1:0] irq_s, irq_d;
  logic [PRIO_W-1:0] task_prio;
  logic mode, busy;
  logic [RCW-1:0] rcnt;

  src_cfg_t [NSRC-1:0] cfg_arr;
  logic [NSRC-1:0][PRIO_W-1:0] prio_arr;
  logic [NSRC-1:0] mask_vec, act_vec, svc_vec, cand_vec, take_vec, retire_vec;

  logic win_valid;
  logic [IW-1:0] win_idx, top_idx;
  logic stk_empty;
  logic [CW-1:0] depth;
  logic [PRIO_W-1:0] svc_prio, thresh, win_prio;
  logic ack_evt, eoi_evt, bus_wr_ok;

  assign bus_wr_ok = bus_wr && !busy;
  assign ack_evt   = bus_rd && (bus_addr == A_ACK) && !busy && win_valid;
  assign eoi_evt   = bus_wr_ok && (bus_addr == A_EOI) && (bus_wdata == 32'd0) && !stk_empty;
  assign svc_prio  = stk_empty ? '0 : prio_arr[top_idx];
  assign thresh    = prio_max(task_prio, svc_prio);
  assign win_prio  = prio_arr[win_idx];
  assign irq_out   = win_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_s <= '0;
      irq_d <= '0;
    end else begin
      irq_s <= irq_in;
      irq_d <= irq_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      task_prio <= 4'hF;
      mode      <= 1'b0;
      busy      <= 1'b0;
      rcnt      <= '0;
    end else if (busy) begin
      task_prio <= 4'hF;
      if (rcnt == '0) busy <= 1'b0;
      else            rcnt <= rcnt - RCW'(1);
    end else if (bus_wr) begin
      if (bus_addr == A_TASK) task_prio <= bus_wdata[3:0];
      if (bus_addr == A_GLOBAL) begin
        mode <= bus_wdata[29];
        if (bus_wdata[31]) begin
          busy <= 1'b1;
          rcnt <= RCW'(RST_CYC - 1);
        end
      end
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic wr_i;
    assign wr_i          = bus_wr_ok && (bus_addr == A_SRC + 8'(i));
    assign take_vec[i]   = ack_evt && (win_idx == IW'(i));
    assign retire_vec[i] = eoi_evt && (top_idx == IW'(i));
    assign prio_arr[i]   = cfg_arr[i].prio;

    irqc_source u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (busy),
      .in_now  (irq_s[i]),
      .in_prev (irq_d[i]),
      .wr_en   (wr_i),
      .wdata   (bus_wdata),
      .ack_take(take_vec[i]),
      .retire  (retire_vec[i]),
      .cfg     (cfg_arr[i]),
      .mask    (mask_vec[i]),
      .active  (act_vec[i]),
      .in_svc  (svc_vec[i]),
      .cand    (cand_vec[i])
    );
  end

  irqc_arbiter #(.NSRC(NSRC)) u_arb (
    .cand     (cand_vec),
    .prio     (prio_arr),
    .thresh   (thresh),
    .win_valid(win_valid),
    .win_idx  (win_idx)
  );

  irqc_nest_stack #(.DEPTH(NEST), .IW(IW)) u_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (busy),
    .push    (ack_evt),
    .push_idx(win_idx),
    .pop     (eoi_evt),
    .top_idx (top_idx),
    .empty   (stk_empty),
    .count   (depth)
  );

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_addr == A_GLOBAL) begin
      bus_rdata = {busy, 1'b0, mode, 29'd0};
    end else if (bus_addr == A_TASK) begin
      bus_rdata = {28'd0, task_prio};
    end else if (bus_addr == A_ACK) begin
      bus_rdata = (win_valid && !busy) ? {24'd0, cfg_arr[win_idx].vec} : {24'd0, SPURIOUS_VEC};
    end else begin
      for (int i = 0; i < NSRC; i++)
        if (bus_addr == A_SRC + 8'(i))
          bus_rdata = pack_src(mask_vec[i], act_vec[i], cfg_arr[i]);
    end
  end

  assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_out);

  assert_masked_never_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !mask_vec[win_idx]);

  assert_above_threshold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |-> (win_prio > task_prio) && (stk_empty || win_prio > svc_prio));

  assert_nest_matches_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(svc_vec) == int'(depth));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int NSRC = 20;
  localparam int RST_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] irq_in = '0;
  logic irq_out;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  irqc_top #(.NSRC(NSRC), .RST_CYC(RST_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // {src_a, prio_a, src_b, prio_b, task_prio, expected ack}
  localparam int TV [8][6] = '{
    '{3, 5, 7, 9, 0, 'h47},
    '{3, 9, 7, 5, 0, 'h43},
    '{3, 6, 7, 6, 0, 'h43},
    '{12, 6, 2, 6, 0, 'h42},
    '{3, 5, 7, 9, 9, 'hFF},
    '{3, 5, 7, 9, 6, 'h47},
    '{3, 5, 7, 4, 5, 'hFF},
    '{19, 15, 0, 1, 14, 'h53}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] src_word(logic m, logic p, logic lv, int pr, int v);
    return {m, 7'd0, p, lv, 2'd0, 4'(pr), 8'd0, 8'(v)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog (all R) actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R1 reset state
    rd(8'h00, d); check("R1 global", d, 32'h0);
    rd(8'h01, d); check("R1 task prio", d, 32'hF);
    rd(8'h25, d); check("R1 source word", d, 32'h8000_0000);
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    rd(8'h02, d); check("R1 ack empty", d, 32'hFF);

    // R6 arbitration table (level, active high, vector 0x40+idx)
    for (int k = 0; k < 8; k++) begin
      wr(8'h01, 32'(TV[k][4]));
      wr(8'h20 + 8'(TV[k][0]), src_word(0, 1, 1, TV[k][1], 'h40 + TV[k][0]));
      wr(8'h20 + 8'(TV[k][2]), src_word(0, 1, 1, TV[k][3], 'h40 + TV[k][2]));
      irq_in[TV[k][0]] = 1'b1; irq_in[TV[k][2]] = 1'b1;
      wait_n(3);
      check($sformatf("R6 irq_out row %0d", k), {31'd0, irq_out}, (TV[k][5] != 'hFF) ? 32'd1 : 32'd0);
      rd(8'h02, d); check($sformatf("R6 R7 ack row %0d", k), d, 32'(TV[k][5]));
      irq_in[TV[k][0]] = 1'b0; irq_in[TV[k][2]] = 1'b0;
      if (TV[k][5] != 'hFF) wr(8'h03, 32'd0);
      wait_n(3);
      wr(8'h20 + 8'(TV[k][0]), src_word(1, 1, 1, TV[k][1], 'h40 + TV[k][0]));
      wr(8'h20 + 8'(TV[k][2]), src_word(1, 1, 1, TV[k][3], 'h40 + TV[k][2]));
    end

    // R10 task priority
    wr(8'h01, 32'hFFFF_FFF0);
    rd(8'h01, d); check("R10 task prio low bits", d, 32'h0);

    // R12 mode
    wr(8'h00, 32'h2000_0000);
    rd(8'h00, d); check("R12 mode readback", d, 32'h2000_0000);

    // R2 layout
    wr(8'h24, 32'h80C3_0055);
    rd(8'h24, d); check("R2 layout", d, 32'h80C3_0055);

    // R3 R4 masked level source active but not delivered
    irq_in[4] = 1'b1; wait_n(3);
    rd(8'h24, d); check("R4 activity while level", d, 32'hC0C3_0055);
    check("R3 masked irq_out", {31'd0, irq_out}, 32'd0);
    rd(8'h02, d); check("R3 masked ack", d, 32'hFF);

    // R9 frozen configuration, mask writable
    wr(8'h24, 32'h80C5_0066);
    rd(8'h24, d); check("R9 cfg frozen", d, 32'hC0C3_0055);
    wr(8'h24, 32'h00C3_0055);
    rd(8'h24, d); check("R9 mask writable", d, 32'h40C3_0055);
    wait_n(1);
    check("R3 unmasked irq_out", {31'd0, irq_out}, 32'd1);
    rd(8'h02, d); check("R7 ack vector", d, 32'h55);
    wait_n(1);
    check("R7 in service blocks irq_out", {31'd0, irq_out}, 32'd0);
    rd(8'h02, d); check("R7 ack spurious", d, 32'hFF);

    // R6 R8 nesting
    wr(8'h29, 32'h00C7_0099); irq_in[9] = 1'b1; wait_n(3);
    check("R6 preempt irq_out", {31'd0, irq_out}, 32'd1);
    rd(8'h02, d); check("R6 preempt ack", d, 32'h99);
    wr(8'h21, 32'h00C5_0011); irq_in[1] = 1'b1; wait_n(3);
    check("R6 below service irq_out", {31'd0, irq_out}, 32'd0);
    rd(8'h02, d); check("R6 below service ack", d, 32'hFF);
    wr(8'h03, 32'd1);
    rd(8'h02, d); check("R8 nonzero eoi ignored", d, 32'hFF);
    irq_in[9] = 1'b0; wait_n(3);
    wr(8'h03, 32'd0);
    rd(8'h02, d); check("R8 pop most recent", d, 32'h11);
    irq_in[1] = 1'b0; irq_in[4] = 1'b0; wait_n(3);
    wr(8'h03, 32'd0); wr(8'h03, 32'd0);
    rd(8'h02, d); check("R8 all retired", d, 32'hFF);
    rd(8'h24, d); check("R8 activity cleared", d, 32'h00C3_0055);

    // R5 edge, rising then falling
    wr(8'h26, 32'h0084_0066);
    irq_in[6] = 1'b1; wait_n(1); irq_in[6] = 1'b0; wait_n(3);
    check("R5 rising latched", {31'd0, irq_out}, 32'd1);
    rd(8'h02, d); check("R5 rising ack", d, 32'h66);
    wr(8'h03, 32'd0); wait_n(1);
    rd(8'h02, d); check("R5 pending cleared", d, 32'hFF);
    wr(8'h26, 32'h0004_0066);
    irq_in[6] = 1'b1; wait_n(3);
    check("R5 no edge on rise when falling", {31'd0, irq_out}, 32'd0);
    irq_in[6] = 1'b0; wait_n(3);
    rd(8'h02, d); check("R5 falling ack", d, 32'h66);
    wr(8'h03, 32'd0);

    // R11 soft reset
    wr(8'h22, 32'h00C2_0022); irq_in[2] = 1'b1; wait_n(3);
    check("R11 pre irq_out", {31'd0, irq_out}, 32'd1);
    wr(8'h00, 32'hA000_0000);
    rd(8'h00, d); check("R11 busy bit", d, 32'hA000_0000);
    check("R11 irq_out low", {31'd0, irq_out}, 32'd0);
    wait_n(RST_CYC + 2);
    rd(8'h00, d); check("R11 R12 self clear mode kept", d, 32'h2000_0000);
    rd(8'h01, d); check("R11 task prio default", d, 32'hF);
    rd(8'h22, d); check("R11 source default", d, 32'h8000_0000);
    check("R11 irq_out after", {31'd0, irq_out}, 32'd0);
    irq_in[2] = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule